// File: doc/BRIEF.md
# Terminal Watchdog and Reset Generator

This block supervises a terminal's control processor. Once a sticky enable bit is set, a watchdog counts ticks of an external 1 ms timebase. Software must service it by writing two distinct step patterns, in order. If no complete service arrives within the timeout window, the block raises a watchdog interrupt and restarts the count. The same enable also turns a shared pin into an active-low wake-up input. A falling edge on that pin raises a wake-up interrupt.

The block can also drive an active-high reset pulse that lasts a fixed number of ticks. A reset-source select bit decides what starts the pulse. With the bit at 0, a wake-up falling edge or a change in the received 4-bit command/indication code starts it. With the bit at 1, only a watchdog overflow starts it. Changing the select bit also restarts the watchdog. Software reaches the block through a small write port that selects one of two registers: control or service.

Top module: `term_supervisor`

## Requirements
- R1: A control write (wr_sel_i=0) with wr_data_i[0]=1 sets the enable bit. No write clears it; only rst_ni does. While the block is disabled, the watchdog does not count and no interrupt or reset pulse occurs.
- R2: While the block is enabled, each falling edge on wake_ni produces exactly one single-cycle wake_irq_o pulse. A rising edge produces none.
- R3: While the block is enabled, TIMEOUT_TICKS tick_i pulses (default 128) after the last restart with no service in between produce a single-cycle wdog_irq_o pulse. The count then restarts from zero.
- R4: A service write (wr_sel_i=1) with wr_data_i=2'b10 (step one), followed later by a service write with wr_data_i=2'b01 (step two), restarts the watchdog count.
- R5: None of the following restarts the watchdog: step two with no step one pending; step one written twice with no step two; step one followed by a service write of any other value and then step two. A service write of any other value discards a pending step one.
- R6: rst_pulse_o rises after a trigger and falls on the PULSE_TICKS-th tick (default 5) after it rises. A trigger that arrives while the pulse is high does not extend it.
- R7: With the select bit at 0, a wake_ni falling edge or a change of ci_code_i starts the reset pulse. A watchdog overflow does not.
- R8: With the select bit at 1, a watchdog overflow starts the reset pulse. Wake-up edges and ci_code_i changes do not.
- R9: The select bit is wr_data_i[1] of a control write and resets to 1. A control write that changes its value restarts the watchdog count.
- R10: After reset, wake_irq_o, wdog_irq_o and rst_pulse_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle 1 ms timebase pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the control register, 1 selects the service register |
| wr_data_i | input | 2 | Write data |
| wake_ni | input | 1 | External wake-up pin, active low, asynchronous |
| ci_code_i | input | 4 | Received command/indication code |
| wake_irq_o | output | 1 | Wake-up interrupt pulse |
| wdog_irq_o | output | 1 | Watchdog overflow interrupt pulse |
| rst_pulse_o | output | 1 | Generated reset pulse, active high |

## Verification
The watchdog is tested with several service sequences against a tick-exact expectation:
- the correct order;
- the reversed order;
- a doubled first step;
- a first step cancelled by a stray value.

Each run checks that the overflow lands on exactly the 128th tick after the last valid restart. This shows whether each sequence restarted the count or not.

The reset pulse is started from each source under both select values, and once again while it is already high. This separates source gating from pulse timing and from retriggering.

Edges on wake_ni and ci_code_i changes are applied both before and after enable, and after an attempt to clear the enable bit. This shows that the enable bit is sticky.

// File: rtl/term_sup_pkg.sv
`timescale 1ns/1ps
package term_sup_pkg;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_RSEL_BIT = 1;
  localparam logic [1:0]  SVC_STEP1     = 2'b10;
  localparam logic [1:0]  SVC_STEP2     = 2'b01;
  typedef enum logic {SEL_CTRL = 1'b0, SEL_SVC = 1'b1} wr_sel_e;
endpackage

// File: rtl/tsup_wake_sync.sv
`timescale 1ns/1ps
module tsup_wake_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  // sr_q[SYNC_STAGES] holds the previous synchronized value
  logic [SYNC_STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[SYNC_STAGES-1:0], pin_i};
  end

  assign fall_o = sr_q[SYNC_STAGES] & ~sr_q[SYNC_STAGES-1];
endmodule

// File: rtl/tsup_wdog.sv
`timescale 1ns/1ps
module tsup_wdog #(
  parameter int unsigned TIMEOUT_TICKS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic step1_i,
  input  logic step2_i,
  input  logic other_i,
  input  logic restart_i,
  output logic ovf_o
);
  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             ovf_q;
  logic             svc_done;
  logic             wrap;

  assign svc_done = step2_i & armed_q;
  assign wrap     = tick_i & (cnt_q == LAST);
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (restart_i || svc_done) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (wrap) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        ovf_q   <= 1'b1;
      end else begin
        if (tick_i) cnt_q <= cnt_q + 1'b1;
        if (step1_i)      armed_q <= 1'b1;
        else if (other_i) armed_q <= 1'b0;
      end
    end
  end

  AST_SVC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && svc_done) |=> (cnt_q == '0 && !ovf_q)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
  AST_OVF_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(tick_i)); // R3
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !ovf_q)); // R1
endmodule

// File: rtl/tsup_pulse.sv
`timescale 1ns/1ps
module tsup_pulse #(
  parameter int unsigned PULSE_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] pcnt_q;
  logic          active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pcnt_q   <= '0;
    end else if (!active_q) begin
      if (trig_i) begin
        active_q <= 1'b1;
        pcnt_q   <= '0;
      end
    end else if (tick_i) begin
      if (pcnt_q == LAST) active_q <= 1'b0;
      else                pcnt_q   <= pcnt_q + 1'b1;
    end
  end

  assign pulse_o = active_q;

  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(trig_i)); // R6
  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i) |=> active_q); // R6
endmodule

// File: rtl/term_supervisor.sv
`timescale 1ns/1ps
module term_supervisor
  import term_sup_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 128,
  parameter int unsigned PULSE_TICKS   = 5,
  parameter int unsigned CI_W          = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [1:0]      wr_data_i,
  input  logic            wake_ni,
  input  logic [CI_W-1:0] ci_code_i,
  output logic            wake_irq_o,
  output logic            wdog_irq_o,
  output logic            rst_pulse_o
);
  logic            en_q;
  logic            rsel_q;
  logic [CI_W-1:0] ci_prev_q;
  logic            wake_irq_q;
  logic            ctrl_wr, svc_wr;
  logic            rsel_chg;
  logic            wake_fall;
  logic            ci_chg;
  logic            ovf;
  logic            trig;

  assign ctrl_wr  = wr_en_i & (wr_sel_i == SEL_CTRL);
  assign svc_wr   = wr_en_i & (wr_sel_i == SEL_SVC);
  assign rsel_chg = ctrl_wr & (wr_data_i[CTRL_RSEL_BIT] != rsel_q);
  assign ci_chg   = (ci_code_i != ci_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      rsel_q     <= 1'b1;
      ci_prev_q  <= '0;
      wake_irq_q <= 1'b0;
    end else begin
      ci_prev_q  <= ci_code_i;
      wake_irq_q <= en_q & wake_fall;
      if (ctrl_wr) begin
        en_q   <= en_q | wr_data_i[CTRL_EN_BIT];
        rsel_q <= wr_data_i[CTRL_RSEL_BIT];
      end
    end
  end

  tsup_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (wake_ni),
    .fall_o (wake_fall)
  );

  tsup_wdog #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .tick_i    (tick_i),
    .step1_i   (svc_wr & (wr_data_i == SVC_STEP1)),
    .step2_i   (svc_wr & (wr_data_i == SVC_STEP2)),
    .other_i   (svc_wr & (wr_data_i != SVC_STEP1) & (wr_data_i != SVC_STEP2)),
    .restart_i (rsel_chg),
    .ovf_o     (ovf)
  );

  // select bit 0: wake-up edge or code change; 1: watchdog overflow
  assign trig = en_q & (rsel_q ? ovf : (wake_fall | ci_chg));

  tsup_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig),
    .tick_i  (tick_i),
    .pulse_o (rst_pulse_o)
  );

  assign wake_irq_o = wake_irq_q;
  assign wdog_irq_o = ovf;

  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q); // R1
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> en_q); // R2
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o); // R2
  AST_RSEL1_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_pulse_o) && $past(rsel_q)) |-> $past(ovf)); // R8
  AST_RSEL0_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_pulse_o) && !$past(rsel_q)) |-> !$past(ovf)); // R7
endmodule

// File: tb/sim_term_supervisor.sv
`timescale 1ns/1ps
module sim_term_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic       wake_n = 1'b1;
  logic [3:0] ci = 4'h0;
  logic       wake_irq, wdog_irq, rst_pulse;

  int checks = 0;
  int failures = 0;
  int wake_cnt = 0;
  int wdog_cnt = 0;
  int rise_cnt = 0;
  logic rst_prev = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  term_supervisor u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .wake_ni(wake_n),
    .ci_code_i(ci), .wake_irq_o(wake_irq), .wdog_irq_o(wdog_irq),
    .rst_pulse_o(rst_pulse)
  );

  always @(negedge clk) begin
    if (wake_irq) wake_cnt++;
    if (wdog_irq) wdog_cnt++;
    if (rst_pulse && !rst_prev) rise_cnt++;
    rst_prev = rst_pulse;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0; #1;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wake_fall();
    @(negedge clk); wake_n = 1'b0;
    cyc(4);
    wake_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset();
    chk("R10 wake_irq", wake_irq, 0);
    chk("R10 wdog_irq", wdog_irq, 0);
    chk("R10 rst_pulse", rst_pulse, 0);
  endtask

  task automatic t_disabled();
    wake_fall();
    @(negedge clk); ci = 4'h5; cyc(3);
    ticks(TO + 2);
    chk("R1 no wake irq while off", wake_cnt, 0);
    chk("R1 no wdog irq while off", wdog_cnt, 0);
    chk("R1 no pulse while off", rise_cnt, 0);
  endtask

  task automatic t_wake_rsel0();
    wr(1'b0, 2'b01); // enable, select 0
    @(negedge clk); wake_n = 1'b0;
    cyc(4);
    chk("R2 wake irq on fall", wake_cnt, 1);
    chk("R7 pulse from wake", rst_pulse, 1);
    wake_n = 1'b1; cyc(4);
    chk("R2 no irq on rise", wake_cnt, 1);
    ticks(4);
    chk("R6 pulse high after 4 ticks", rst_pulse, 1);
    ticks(1);
    chk("R6 pulse low after 5 ticks", rst_pulse, 0);
  endtask

  task automatic t_ci_retrig();
    @(negedge clk); ci = 4'h3; cyc(2);
    chk("R7 pulse from ci change", rst_pulse, 1);
    chk("R7 ci rise count", rise_cnt, 2);
    ticks(2);
    wake_fall();
    chk("R2 wake irq second", wake_cnt, 2);
    ticks(2);
    chk("R6 retrigger keeps high", rst_pulse, 1);
    ticks(1);
    chk("R6 retrigger not extended", rst_pulse, 0);
    chk("R6 single rise", rise_cnt, 2);
  endtask

  task automatic service();
    wr(1'b1, 2'b10);
    wr(1'b1, 2'b01);
  endtask

  task automatic t_timeout();
    int w0;
    service();
    w0 = wdog_cnt;
    ticks(TO - 1);
    chk("R3 no overflow before limit", wdog_cnt, w0);
    ticks(1);
    chk("R3 overflow at limit", wdog_cnt, w0 + 1);
    cyc(2);
    chk("R7 overflow no pulse with sel 0", rise_cnt, 2);
  endtask

  task automatic t_service_ok();
    int w0;
    w0 = wdog_cnt;
    ticks(100);
    service();
    ticks(TO - 1);
    chk("R4 service restarted count", wdog_cnt, w0);
    ticks(1);
    chk("R4 overflow after service", wdog_cnt, w0 + 1);
  endtask

  task automatic t_bad_order();
    int w0;
    w0 = wdog_cnt;
    ticks(100);
    wr(1'b1, 2'b01);
    wr(1'b1, 2'b10);
    ticks(TO - 101);
    chk("R5 step2 then step1 before limit", wdog_cnt, w0);
    ticks(1);
    chk("R5 step2 then step1 no service", wdog_cnt, w0 + 1);
    w0 = wdog_cnt;
    ticks(100);
    wr(1'b1, 2'b10);
    wr(1'b1, 2'b10);
    ticks(TO - 100);
    chk("R5 step1 twice no service", wdog_cnt, w0 + 1);
    w0 = wdog_cnt;
    ticks(100);
    wr(1'b1, 2'b10);
    wr(1'b1, 2'b00);
    wr(1'b1, 2'b01);
    ticks(TO - 100);
    chk("R5 other value cancels step1", wdog_cnt, w0 + 1);
  endtask

  task automatic t_rsel_toggle();
    int w0;
    w0 = wdog_cnt;
    ticks(100);
    wr(1'b0, 2'b11); // select 1, restarts watchdog
    ticks(TO - 1);
    chk("R9 select change restarted count", wdog_cnt, w0);
    ticks(1);
    chk("R9 overflow after select change", wdog_cnt, w0 + 1);
    cyc(1);
    chk("R8 overflow starts pulse", rst_pulse, 1);
    chk("R8 rise count", rise_cnt, 3);
    ticks(5);
    chk("R6 overflow pulse ended", rst_pulse, 0);
  endtask

  task automatic t_rsel1_block();
    wake_fall();
    chk("R2 wake irq with sel 1", wake_cnt, 3);
    chk("R8 wake no pulse", rise_cnt, 3);
    @(negedge clk); ci = 4'h9; cyc(3);
    chk("R8 ci change no pulse", rise_cnt, 3);
  endtask

  task automatic t_sticky();
    wr(1'b0, 2'b10); // enable bit 0, select stays 1
    wake_fall();
    chk("R1 enable stays set", wake_cnt, 4);
  endtask

  localparam int TO = 128;

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_disabled();
    t_wake_rsel0();
    t_ci_retrig();
    t_timeout();
    t_service_ok();
    t_bad_order();
    t_rsel_toggle();
    t_rsel1_block();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule